// File: doc/BRIEF.md
# Shader Operand Fetch and Swizzle

This block collects the source operands for one shader instruction. It takes one wide (7-bit) source register number and two narrow (5-bit) source register numbers. It also takes a 2-bit relative-index selector, three signed address offsets and a 32-bit operand descriptor word. From these it produces three four-lane source vectors and a destination write mask, one clock after a fetch request.

A single register array holds the input, temporary and constant registers in one 128-entry raw address space, and a host port fills it. The wide source can apply a relative offset, but only when it names a constant register. An offset that lands outside the constant range reads an all-zero vector and sets an error flag that stays set. Each source is then lane-swizzled and can be negated under control of its own fields in the descriptor.

Top module: `shader_opnd_fetch`

## Requirements
- R1: Raw register numbers 0x00-0x0F address input registers, 0x10-0x1F address temporaries and 0x20-0x7F address constants c0-c95. The host write port uses the same raw numbering, and each entry is 96 bits with lane i at bits [24i+23:24i] (lane 0 = x, lane 3 = w).
- R2: `rel_sel` encodings are 0 = no offset, 1 = `ofs_ax`, 2 = `ofs_ay` and 3 = `ofs_loop`. Each offset is a signed 8-bit value added to the constant number of the wide source, so c8 with +3 reads c11 and c16 with -5 reads c11.
- R3: When the wide source names an input or temporary register, the selected offset is ignored and the register is read unmodified.
- R4: A relative constant number below 0 or above 95 reads an all-zero vector before negation and sets `range_err`. `range_err` stays set until reset.
- R5: In every 8-bit selector, bits [7:6] pick the source lane for output lane 0, bits [5:4] for lane 1, bits [3:2] for lane 2 and bits [1:0] for lane 3, with 0 = x, 1 = y, 2 = z, 3 = w. 0x1B is the identity swizzle and 0x55 broadcasts y.
- R6: A set negate flag inverts only bit 23 of every lane of its own source and leaves the other sources unchanged.
- R7: The descriptor fields are: write mask [3:0] (bit 3 = x, bit 2 = y, bit 1 = z, bit 0 = w), source-1 negate bit 4 and selector [12:5], source-2 negate bit 13 and selector [21:14], source-3 negate bit 22 and selector [30:23]. `out_wmask` carries the write mask.
- R8: `out_valid` rises exactly one cycle after `fetch_valid`. Without a request, `out_valid` is low and the output vectors hold their last values.
- R9: The two narrow source fields are 5 bits wide, so they can address only inputs and temporaries (raw 0x00-0x1F), and they never use an offset.
- R10: After reset, `out_valid` and `range_err` are low and all output vectors and the mask are zero.
- R11: A host write to an entry is returned by a fetch issued on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 7 | Raw register number to write |
| host_data | input | 96 | Four-lane write data |
| fetch_valid | input | 1 | Fetch request |
| src1_raw | input | 7 | Wide source register number |
| src2_raw | input | 5 | Narrow source 2 register number |
| src3_raw | input | 5 | Narrow source 3 register number |
| rel_sel | input | 2 | Relative offset selector for source 1 |
| ofs_ax | input | 8 | Signed offset register x |
| ofs_ay | input | 8 | Signed offset register y |
| ofs_loop | input | 8 | Signed loop-counter offset |
| desc | input | 32 | Operand descriptor word |
| out_valid | output | 1 | Operands valid |
| out_src1 | output | 96 | Swizzled source 1 |
| out_src2 | output | 96 | Swizzled source 2 |
| out_src3 | output | 96 | Swizzled source 3 |
| out_wmask | output | 4 | Destination write mask |
| range_err | output | 1 | Sticky relative-range error |

## Verification
The register array is preloaded so that every lane encodes its own raw address and lane number. Any wrong class decode, offset or swizzle therefore appears as a distinct value. The vectors cover:
- every offset selector against constant bases, including negative offsets and both ends of c0-c95;
- the same offsets against input and temporary bases, where they must have no effect;
- identity, broadcast and reversed swizzles, with negation on a single source, which separates per-source decode from per-lane decode.

Directed cases then cover the reset state, holding the outputs while idle, a host write read back on the next cycle, and offsets that leave the constant range in either direction, one of them combined with negation.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int LANE_W     = 24;
  localparam int LANES      = 4;
  localparam int VEC_W      = LANE_W * LANES;
  localparam int RAW_W      = 7;
  localparam int NARROW_W   = 5;
  localparam int OFS_W      = 8;
  localparam int CONST_BASE = 32;
  localparam int N_CONST    = 96;
  localparam int N_ENTRY    = 1 << RAW_W;
  localparam int N_SRC      = 3;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/sof_regfile.sv
module sof_regfile #(
  parameter int ENTRIES = sof_pkg::N_ENTRY,
  parameter int AW      = sof_pkg::RAW_W,
  parameter int DW      = sof_pkg::VEC_W,
  parameter int PORTS   = sof_pkg::N_SRC
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [PORTS],
  output logic [DW-1:0] rdata [PORTS]
);
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/sof_rel_resolve.sv
module sof_rel_resolve #(
  parameter int RAW_W      = sof_pkg::RAW_W,
  parameter int OFS_W      = sof_pkg::OFS_W,
  parameter int CONST_BASE = sof_pkg::CONST_BASE,
  parameter int N_CONST    = sof_pkg::N_CONST
) (
  input  logic             [RAW_W-1:0] raw,
  input  logic             [1:0]       rel_sel,
  input  logic signed      [OFS_W-1:0] ofs_ax,
  input  logic signed      [OFS_W-1:0] ofs_ay,
  input  logic signed      [OFS_W-1:0] ofs_loop,
  output logic             [RAW_W-1:0] rd_addr,
  output logic                         oob
);
  localparam int EW = ((RAW_W > OFS_W) ? RAW_W : OFS_W) + 2;

  logic                   is_const;
  logic [RAW_W-1:0]       cnum;
  logic signed [OFS_W-1:0] ofs;
  logic signed [EW-1:0]   eff;

  always_comb begin
    is_const = (raw >= RAW_W'(CONST_BASE));
    cnum     = raw - RAW_W'(CONST_BASE);
    unique case (rel_sel)
      2'd1:    ofs = ofs_ax;
      2'd2:    ofs = ofs_ay;
      2'd3:    ofs = ofs_loop;
      default: ofs = '0;
    endcase
    eff = $signed({{(EW-RAW_W){1'b0}}, cnum}) + EW'(ofs);
    if (!is_const) begin
      rd_addr = raw;
      oob     = 1'b0;
    end else begin
      oob     = eff[EW-1] || (eff >= EW'(N_CONST));
      rd_addr = oob ? raw : (RAW_W'(eff) + RAW_W'(CONST_BASE));
    end
  end

  // R4 / R1: an in-range relative constant read stays inside the constant class
  always_comb begin
    if (is_const && !oob)
      a_r4_const_stays_const: assert (rd_addr >= RAW_W'(CONST_BASE));
  end
endmodule

// File: rtl/sof_swizzle.sv
module sof_swizzle #(
  parameter int LANE_W = sof_pkg::LANE_W,
  parameter int LANES  = sof_pkg::LANES
) (
  input  logic [LANE_W*LANES-1:0] vin,
  input  logic [2*LANES-1:0]      sel,
  input  logic                    neg,
  output logic [LANE_W*LANES-1:0] vout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]        pick;
    logic [LANE_W-1:0] lane;
    assign pick = sel[2*(LANES-1-i) +: 2];
    assign lane = vin[LANE_W*pick +: LANE_W];
    assign vout[LANE_W*i +: LANE_W] = {lane[LANE_W-1] ^ neg, lane[LANE_W-2:0]};
  end
endmodule

// File: rtl/shader_opnd_fetch.sv
module shader_opnd_fetch
  import sof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [RAW_W-1:0]  host_addr,
  input  logic [VEC_W-1:0]  host_data,
  input  logic              fetch_valid,
  input  logic [RAW_W-1:0]  src1_raw,
  input  logic [NARROW_W-1:0] src2_raw,
  input  logic [NARROW_W-1:0] src3_raw,
  input  logic [1:0]        rel_sel,
  input  logic [OFS_W-1:0]  ofs_ax,
  input  logic [OFS_W-1:0]  ofs_ay,
  input  logic [OFS_W-1:0]  ofs_loop,
  input  logic [31:0]       desc,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_src1,
  output logic [VEC_W-1:0]  out_src2,
  output logic [VEC_W-1:0]  out_src3,
  output logic [3:0]        out_wmask,
  output logic              range_err
);
  localparam int SEL_W = 2 * LANES;
  // descriptor field positions (R7)
  localparam int NEG_POS [N_SRC] = '{4, 13, 22};
  localparam int SEL_POS [N_SRC] = '{5, 14, 23};

  logic [RAW_W-1:0] raddr [N_SRC];
  logic [VEC_W-1:0] rdata [N_SRC];
  logic [VEC_W-1:0] fetched [N_SRC];
  logic [VEC_W-1:0] swz [N_SRC];
  logic [RAW_W-1:0] src1_addr;
  logic             src1_oob;

  sof_rel_resolve u_rel (
    .raw      (src1_raw),
    .rel_sel  (rel_sel),
    .ofs_ax   (ofs_ax),
    .ofs_ay   (ofs_ay),
    .ofs_loop (ofs_loop),
    .rd_addr  (src1_addr),
    .oob      (src1_oob)
  );

  assign raddr[0] = src1_addr;
  assign raddr[1] = {{(RAW_W-NARROW_W){1'b0}}, src2_raw};
  assign raddr[2] = {{(RAW_W-NARROW_W){1'b0}}, src3_raw};

  sof_regfile u_rf (
    .clk   (clk),
    .we    (host_we),
    .waddr (host_addr),
    .wdata (host_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign fetched[0] = src1_oob ? '0 : rdata[0];
  assign fetched[1] = rdata[1];
  assign fetched[2] = rdata[2];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    sof_swizzle u_swz (
      .vin  (fetched[s]),
      .sel  (desc[SEL_POS[s] +: SEL_W]),
      .neg  (desc[NEG_POS[s]]),
      .vout (swz[s])
    );
  end

  // next-state
  logic             valid_d, err_d;
  logic [VEC_W-1:0] s1_d, s2_d, s3_d;
  logic [3:0]       mask_d;
  always_comb begin
    valid_d = fetch_valid;
    err_d   = range_err | (fetch_valid & src1_oob);
    s1_d    = fetch_valid ? swz[0] : out_src1;
    s2_d    = fetch_valid ? swz[1] : out_src2;
    s3_d    = fetch_valid ? swz[2] : out_src3;
    mask_d  = fetch_valid ? desc[3:0] : out_wmask;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      range_err <= 1'b0;
      out_src1  <= '0;
      out_src2  <= '0;
      out_src3  <= '0;
      out_wmask <= '0;
    end else begin
      out_valid <= valid_d;
      range_err <= err_d;
      out_src1  <= s1_d;
      out_src2  <= s2_d;
      out_src3  <= s3_d;
      out_wmask <= mask_d;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_valid);
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !out_valid);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> ($stable(out_src1) && $stable(out_src2) && $stable(out_src3)));
  a_r4_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);
  a_r4_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && src1_oob && !desc[4]) |=> (out_src1 == '0) && range_err);
  a_r7_mask_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_wmask == $past(desc[3:0]));
endmodule

// File: tb/shader_opnd_fetch_bench.sv
module shader_opnd_fetch_bench;
  typedef struct packed {
    logic [6:0] s1; logic [4:0] s2; logic [4:0] s3; logic [1:0] rel;
    logic [7:0] ax; logic [7:0] ay; logic [7:0] al;
    logic [3:0] mask;
    logic n1; logic [7:0] w1; logic n2; logic [7:0] w2; logic n3; logic [7:0] w3;
  } tv_t;

  localparam int NV = 10;
  localparam tv_t TBL [NV] = '{
    // R1 input/temp/input, identity swizzles
    '{7'h03, 5'h12, 5'h07, 2'd0, 8'd0,   8'd0,   8'd0,   4'hF, 1'b0, 8'h1B, 1'b0, 8'h1B, 1'b0, 8'h1B},
    // R3 temp base ignores a0x; R5 broadcast/reverse; R6 neg on src2
    '{7'h15, 5'h1F, 5'h00, 2'd1, 8'd3,   8'd0,   8'd0,   4'hA, 1'b0, 8'h55, 1'b1, 8'hE4, 1'b0, 8'h1B},
    // R2 c8 + a0x(3) -> c11
    '{7'h28, 5'h01, 5'h02, 2'd1, 8'd3,   8'd0,   8'd0,   4'h5, 1'b0, 8'h1B, 1'b0, 8'h00, 1'b0, 8'hFF},
    // R2 c16 + a0y(-5) -> c11, negate src1
    '{7'h30, 5'h10, 5'h11, 2'd2, 8'd0,   8'hFB,  8'd0,   4'h3, 1'b1, 8'h1B, 1'b0, 8'h1B, 1'b0, 8'hAA},
    // R2 c0 + aL(95) -> c95 upper boundary
    '{7'h20, 5'h0F, 5'h1E, 2'd3, 8'd0,   8'd0,   8'd95,  4'h8, 1'b0, 8'h1B, 1'b0, 8'h1B, 1'b1, 8'h1B},
    // R1 c95 direct
    '{7'h7F, 5'h08, 5'h18, 2'd0, 8'd7,   8'd7,   8'd7,   4'h1, 1'b0, 8'h93, 1'b0, 8'h1B, 1'b0, 8'h1B},
    // R3 input base ignores aL(-128)
    '{7'h0A, 5'h04, 5'h14, 2'd3, 8'd0,   8'd0,   8'h80,  4'h6, 1'b0, 8'h1B, 1'b0, 8'h39, 1'b0, 8'h1B},
    // R2 c0 + a0y(0), R6 negate src3 only
    '{7'h20, 5'h05, 5'h06, 2'd2, 8'd0,   8'd0,   8'd0,   4'h8, 1'b0, 8'h00, 1'b0, 8'h1B, 1'b1, 8'h1B},
    // R4 c0 + a0x(-1) -> below range
    '{7'h20, 5'h09, 5'h19, 2'd1, 8'hFF,  8'd0,   8'd0,   4'hF, 1'b0, 8'h1B, 1'b0, 8'h1B, 1'b0, 8'h1B},
    // R4 c95 + aL(1) -> above range, negated zero
    '{7'h7F, 5'h0B, 5'h1B, 2'd3, 8'd0,   8'd0,   8'd1,   4'h2, 1'b1, 8'h1B, 1'b0, 8'h1B, 1'b0, 8'h1B}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [6:0]  host_addr;
  logic [95:0] host_data;
  logic        fetch_valid;
  logic [6:0]  src1_raw;
  logic [4:0]  src2_raw, src3_raw;
  logic [1:0]  rel_sel;
  logic [7:0]  ofs_ax, ofs_ay, ofs_loop;
  logic [31:0] desc;
  logic        out_valid, range_err;
  logic [95:0] out_src1, out_src2, out_src3;
  logic [3:0]  out_wmask;

  always #4 clk = ~clk;

  shader_opnd_fetch u_shader_opnd_fetch (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .fetch_valid(fetch_valid), .src1_raw(src1_raw),
    .src2_raw(src2_raw), .src3_raw(src3_raw), .rel_sel(rel_sel),
    .ofs_ax(ofs_ax), .ofs_ay(ofs_ay), .ofs_loop(ofs_loop), .desc(desc),
    .out_valid(out_valid), .out_src1(out_src1), .out_src2(out_src2),
    .out_src3(out_src3), .out_wmask(out_wmask), .range_err(range_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [95:0] shadow [128];
  logic exp_err = 1'b0;

  function automatic logic [95:0] pat(input int a);
    logic [95:0] v;
    for (int i = 0; i < 4; i++) v[24*i +: 24] = {1'b0, 7'(a), 2'(i), 14'h0A5};
    return v;
  endfunction

  function automatic logic [95:0] swz(input logic [95:0] v, input logic [7:0] s, input logic n);
    logic [95:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [1:0]  c;
      logic [23:0] l;
      c = s[2*(3-i) +: 2];
      l = v[24*c +: 24];
      l[23] = l[23] ^ n;
      r[24*i +: 24] = l;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [95:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 7'(a); host_data = d;
    shadow[a] = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_vec(input tv_t t);
    logic [95:0] e1, e2, e3;
    logic        oob;
    int          eff;
    int          o;
    oob = 1'b0;
    if (t.s1 >= 7'h20) begin
      case (t.rel)
        2'd1: o = int'($signed(t.ax));
        2'd2: o = int'($signed(t.ay));
        2'd3: o = int'($signed(t.al));
        default: o = 0;
      endcase
      eff = int'(t.s1) - 32 + o;
      if (eff < 0 || eff > 95) begin oob = 1'b1; e1 = '0; end
      else e1 = shadow[eff + 32];
    end else e1 = shadow[t.s1];
    e1 = swz(e1, t.w1, t.n1);
    e2 = swz(shadow[t.s2], t.w2, t.n2);
    e3 = swz(shadow[t.s3], t.w3, t.n3);
    if (oob) exp_err = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b1; src1_raw = t.s1; src2_raw = t.s2; src3_raw = t.s3;
    rel_sel = t.rel; ofs_ax = t.ax; ofs_ay = t.ay; ofs_loop = t.al;
    desc = {1'b0, t.w3, t.n3, t.w2, t.n2, t.w1, t.n1, t.mask};
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R8 valid", 96'(out_valid), 96'(1));
    chk("R1/R2/R3/R4/R5/R6 src1", out_src1, e1);
    chk("R9/R5/R6 src2", out_src2, e2);
    chk("R9/R5/R6 src3", out_src3, e3);
    chk("R7 wmask", 96'(out_wmask), 96'(t.mask));
    chk("R4 range_err", 96'(range_err), 96'(exp_err));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [95:0] held;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_data = '0;
    fetch_valid = 1'b0; src1_raw = '0; src2_raw = '0; src3_raw = '0;
    rel_sel = '0; ofs_ax = '0; ofs_ay = '0; ofs_loop = '0; desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 96'(out_valid), 96'(0));
    chk("R10 range_err", 96'(range_err), 96'(0));
    chk("R10 src1", out_src1, '0);
    chk("R10 src2", out_src2, '0);
    chk("R10 src3", out_src3, '0);
    chk("R10 wmask", 96'(out_wmask), 96'(0));

    for (int a = 0; a < 128; a++) hwrite(a, pat(a));

    for (int k = 0; k < NV; k++) run_vec(TBL[k]);

    // R8 hold while idle
    held = out_src1;
    @(negedge clk);
    chk("R8 idle valid", 96'(out_valid), 96'(0));
    chk("R8 hold src1", out_src1, held);
    chk("R4 sticky", 96'(range_err), 96'(1));

    // R11 host write visible to the next-cycle fetch
    hwrite(7'h25, 96'h5A5A5A_3C3C3C_0F0F0F_123456);
    run_vec('{7'h25, 5'h00, 5'h10, 2'd0, 8'd0, 8'd0, 8'd0, 4'hF,
              1'b0, 8'h1B, 1'b0, 8'h1B, 1'b0, 8'h1B});

    // R10 reset clears sticky flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 err cleared", 96'(range_err), 96'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule